// File: doc/BRIEF.md
# Restoring Sequential Divider

This block divides an unsigned dividend of twice the divisor width by an unsigned divisor. It works one quotient bit per clock. The dividend is split over two working registers. The upper half sits in the partial-remainder register and the lower half in the quotient register. The divisor is held in its own register for the whole operation. Each cycle shifts the pair of working registers left by one bit. It then tries to subtract the divisor from the upper half. When the subtraction borrows, the upper half is restored. The new quotient bit drops into the bit position that the shift left empty.

Before any step runs, a check looks at the operands. If the divisor is zero, or if it is not greater than the upper half of the dividend, the quotient could not fit in the divisor width. In that case the operation is refused at once and an exception flag is raised. A caller pulses `start_i` with the operands and waits for `done_o`. It reads `exc_o`, `quot_o` and `rem_o` in that cycle. The results stay readable until the next accepted start.

Top module: `restoring_divider`

## Requirements
- R1: After reset, `done_o`, `exc_o`, `quot_o` and `rem_o` are all zero.
- R2: A start with divisor zero asserts `done_o` and `exc_o` together, right after the clock edge that samples `start_i`.
- R3: A start whose divisor is nonzero but less than or equal to dividend bits [2W-1:W] is refused in the same way as R2: `done_o` and `exc_o` are high right after the sampling edge.
- R4: An accepted start raises `done_o` after exactly W clock edges following the edge that samples `start_i`.
- R5: On completion of an accepted start, `quot_o` equals dividend / divisor and `rem_o` equals dividend mod divisor, both unsigned.
- R6: `exc_o` is low in every cycle in which `done_o` is high after an accepted start. `exc_o` is never high without `done_o`.
- R7: `done_o` stays high for a single cycle unless a new start is sampled in that same cycle.
- R8: A pulse on `start_i` while a division is in progress is ignored. The running division finishes with its original operands and its original timing.
- R9: `quot_o` and `rem_o` hold their values after completion until the next accepted start.
- R10: The divisor 00101010 / 0111 case gives quotient 0110 and remainder 0000. Shifted partial remainders of 2^W or more, for example 0xEF / 0xF, still give correct results.
- R11: A start sampled in the cycle where `done_o` is high is accepted. It is checked and executed like any start from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a division with the present operands (sampled when idle) |
| dividend_i | input | 2*W | Unsigned dividend |
| divisor_i | input | W | Unsigned divisor |
| done_o | output | 1 | One-cycle completion pulse |
| exc_o | output | 1 | High with `done_o` when the operation was refused |
| quot_o | output | W | Quotient (undefined after a refusal) |
| rem_o | output | W | Remainder (undefined after a refusal) |

## Verification
Two functions can land in the same cycle: the completion pulse of one division and the acceptance of the next start. That cycle also carries its exception check. The bench provokes this by issuing the next operation on the very sample where it sees `done_o` high. It uses valid and refused operands in random order. It then judges both results and their latencies against a reference model. It also injects a start one cycle into a running division. It expects the first result unchanged and at its normal latency.

// File: rtl/div_pkg.sv
// Package: shared types for the restoring divider.
// Assumes: nothing beyond IEEE 1800-2017.
package div_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;
endpackage

// File: rtl/div_precheck.sv
// Module: div_precheck
// Decides whether an operation can proceed. The quotient fits in W bits only
// when the divisor is nonzero and strictly greater than the upper dividend half.
// Assumes: purely combinational, inputs are the raw operands.
module div_precheck #(
    parameter int W = 4
) (
    input  logic [2*W-1:0] dividend,
    input  logic [W-1:0]   divisor,
    output logic           reject
);
    logic [W-1:0] upper;

    // Pick the half that lands in the partial-remainder register.
    always_comb upper = dividend[2*W-1:W];

    // Refuse on zero divisor or on a quotient that would overflow.
    always_comb reject = (divisor == '0) || (divisor <= upper);
endmodule

// File: rtl/div_step.sv
// Module: div_step
// One shift-subtract-restore iteration. The bit shifted out of the partial
// remainder is kept, so the trial subtraction runs on W+1 bits.
// Assumes: acc < mdr on entry (guaranteed by the precheck), combinational.
module div_step #(
    parameter int W = 4
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] mq,
    input  logic [W-1:0] mdr,
    output logic [W-1:0] acc_nxt,
    output logic [W-1:0] mq_nxt
);
    localparam int EW = W + 1;

    logic [EW-1:0] shifted;
    logic [EW:0]   trial;
    logic          borrow;

    // Shift the working pair left: upper half gains the top bit of mq.
    always_comb shifted = {acc, mq[W-1]};

    // Trial subtraction with one guard bit to expose the borrow.
    always_comb begin
        trial  = {1'b0, shifted} - {2'b00, mdr};
        borrow = trial[EW];
    end

    // Keep the difference or restore, and insert the quotient bit.
    always_comb begin
        acc_nxt = borrow ? shifted[W-1:0] : trial[W-1:0];
        mq_nxt  = {mq[W-2:0], ~borrow};
    end
endmodule

// File: rtl/div_ctrl.sv
// Module: div_ctrl
// Sequencer: accepts a start when idle, refuses it at once on a precheck
// failure, otherwise runs W step cycles and pulses done.
// Assumes: synchronous active-low reset; W >= 2.
module div_ctrl
    import div_pkg::*;
#(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic reject,
    output logic load,
    output logic step,
    output logic busy,
    output logic done,
    output logic exc
);
    localparam int CW = $clog2(W) + 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    div_state_e    state;
    logic [CW-1:0] cnt;

    // Decode the datapath strobes from state and request.
    always_comb begin
        load = (state == ST_IDLE) && start && !reject;
        step = (state == ST_RUN);
        busy = (state == ST_RUN);
    end

    // State, step counter and the registered done/exception pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
            exc   <= 1'b0;
        end else begin
            done <= 1'b0;
            exc  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start && reject) begin
                        done <= 1'b1;
                        exc  <= 1'b1;
                    end else if (start) begin
                        state <= ST_RUN;
                        cnt   <= '0;
                    end
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_EXC_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        exc |-> done); // R6
    AST_REFUSE_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && reject) |=> (done && exc)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done || $past(start))); // R7
endmodule

// File: rtl/restoring_divider.sv
// Module: restoring_divider (top)
// Unsigned 2W-by-W restoring divider, one quotient bit per clock.
// Holds the working registers and instantiates the precheck, step and control.
// Assumes: operands are stable in the cycle start_i is high.
module restoring_divider #(
    parameter int W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [2*W-1:0] dividend_i,
    input  logic [W-1:0]   divisor_i,
    output logic           done_o,
    output logic           exc_o,
    output logic [W-1:0]   quot_o,
    output logic [W-1:0]   rem_o
);
    logic [W-1:0] acc_q, mq_q, mdr_q;
    logic [W-1:0] acc_nxt, mq_nxt;
    logic         reject, load, step, busy;

    div_precheck #(.W(W)) u_check (
        .dividend (dividend_i),
        .divisor  (divisor_i),
        .reject   (reject)
    );

    div_step #(.W(W)) u_step (
        .acc     (acc_q),
        .mq      (mq_q),
        .mdr     (mdr_q),
        .acc_nxt (acc_nxt),
        .mq_nxt  (mq_nxt)
    );

    div_ctrl #(.W(W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_i),
        .reject (reject),
        .load   (load),
        .step   (step),
        .busy   (busy),
        .done   (done_o),
        .exc    (exc_o)
    );

    // Working registers: load the split dividend and divisor, then iterate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            mq_q  <= '0;
            mdr_q <= '0;
        end else if (load) begin
            acc_q <= dividend_i[2*W-1:W];
            mq_q  <= dividend_i[W-1:0];
            mdr_q <= divisor_i;
        end else if (step) begin
            acc_q <= acc_nxt;
            mq_q  <= mq_nxt;
        end
    end

    // Results are read straight from the working registers.
    always_comb begin
        quot_o = mq_q;
        rem_o  = acc_q;
    end

    AST_ACC_BELOW_MDR: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (acc_q < mdr_q)); // R10
    AST_MDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mdr_q)); // R8
    AST_REM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !exc_o) |-> (rem_o < mdr_q)); // R5
endmodule

// File: tb/tb_restoring_divider.sv
`timescale 1ns/1ps
module tb_restoring_divider;
    localparam int W = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [2*W-1:0] dividend_i = '0;
    logic [W-1:0]   divisor_i = '0;
    logic           done_o, exc_o;
    logic [W-1:0]   quot_o, rem_o;

    int n_chk = 0;
    int n_fail = 0;

    restoring_divider #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i),
        .done_o(done_o), .exc_o(exc_o), .quot_o(quot_o), .rem_o(rem_o)
    );

    always #2.5 clk = ~clk;

    function automatic bit exp_refuse(input logic [2*W-1:0] dd, input logic [W-1:0] dv);
        return (dv == 0) || (dv <= dd[2*W-1:W]);
    endfunction

    function automatic logic [W-1:0] exp_quot(input logic [2*W-1:0] dd, input logic [W-1:0] dv);
        return W'(dd / dv);
    endfunction

    function automatic logic [W-1:0] exp_rem(input logic [2*W-1:0] dd, input logic [W-1:0] dv);
        return W'(dd % dv);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Issue at a negedge; return at the negedge after the sampling posedge.
    task automatic issue(input logic [2*W-1:0] dd, input logic [W-1:0] dv, input bit poke);
        start_i = 1'b1; dividend_i = dd; divisor_i = dv;
        @(negedge clk);
        start_i = 1'b0;
        if (poke && !exp_refuse(dd, dv)) begin
            // R8: a start during the run with other operands must be ignored
            start_i = 1'b1; dividend_i = 8'h10; divisor_i = 4'h3;
        end
    endtask

    // Wait for done; leaves the bench at the negedge where done is seen.
    task automatic finish_op(input logic [2*W-1:0] dd, input logic [W-1:0] dv,
                             input bit poke, input bit hold);
        int lat = 0;
        bit ref_exc = exp_refuse(dd, dv);
        while (!done_o && lat < 40) begin
            @(negedge clk);
            start_i = 1'b0;
            lat++;
        end
        if (ref_exc) begin
            chk(lat == 0, (dv == 0) ? "R2 latency" : "R3 latency", lat, 0);
            chk(exc_o == 1'b1, (dv == 0) ? "R2 exc" : "R3 exc", exc_o, 1);
        end else begin
            chk(lat == W, poke ? "R8 latency" : "R4 latency", lat, W);
            chk(exc_o == 1'b0, "R6 exc low", exc_o, 0);
            chk(quot_o == exp_quot(dd, dv), poke ? "R8 quotient" : "R5 quotient",
                quot_o, exp_quot(dd, dv));
            chk(rem_o == exp_rem(dd, dv), poke ? "R8 remainder" : "R5 remainder",
                rem_o, exp_rem(dd, dv));
        end
        if (hold) begin
            logic [W-1:0] q0 = quot_o, r0 = rem_o;
            @(negedge clk);
            chk(done_o == 1'b0, "R7 single pulse", done_o, 0);
            chk(exc_o == 1'b0, "R6 no stray exc", exc_o, 0);
            repeat (3) @(negedge clk);
            chk(quot_o == q0 && rem_o == r0, "R9 hold", {quot_o, rem_o}, {q0, r0});
        end
    endtask

    task automatic run(input logic [2*W-1:0] dd, input logic [W-1:0] dv,
                       input bit poke, input bit hold);
        issue(dd, dv, poke);
        finish_op(dd, dv, poke, hold);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done_o == 0 && exc_o == 0, "R1 flags", {done_o, exc_o}, 0);
        chk(quot_o == 0 && rem_o == 0, "R1 data", {quot_o, rem_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run(8'h2A, 4'h7, 1'b0, 1'b1);   // R10 worked example
        chk(quot_o == 4'h6 && rem_o == 4'h0, "R10 example", {quot_o, rem_o}, 8'h60);
        run(8'hEF, 4'hF, 1'b0, 1'b1);   // R10 partial remainder >= 2^W
        run(8'h55, 4'h0, 1'b0, 1'b1);   // R2 zero divisor
        run(8'h35, 4'h3, 1'b0, 1'b1);   // R3 equal to upper half
        run(8'h95, 4'h3, 1'b0, 1'b1);   // R3 below upper half
        run(8'h00, 4'h1, 1'b0, 1'b1);   // R5 zero dividend
        run(8'h0F, 4'h1, 1'b0, 1'b1);   // R5 divisor one
        run(8'h6C, 4'h9, 1'b1, 1'b1);   // R8 start during run
        // R11: back-to-back, next start issued on the done sample
        run(8'h3B, 4'h5, 1'b0, 1'b0);
        run(8'h70, 4'h0, 1'b0, 1'b0);   // R11 refusal right after done
        run(8'hC7, 4'hD, 1'b0, 1'b1);

        void'($urandom(32'd2718));
        for (int i = 0; i < 400; i++) begin
            logic [2*W-1:0] dd;
            logic [W-1:0]   dv;
            dv = W'($urandom_range(0, 15));
            dd = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 3) != 0 && dv != 0)
                dd[2*W-1:W] = W'($urandom_range(0, int'(dv) - 1));
            run(dd, dv, ($urandom_range(0, 7) == 0), ($urandom_range(0, 2) == 0));
        end

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule